// File: doc/BRIEF.md
# Integer ALU with Selectable Overflow Policy

This block is a two-operand integer arithmetic and logic unit for a processor execute stage. It computes bitwise AND, bitwise OR, addition and subtraction on two's-complement operands. For the two arithmetic operations it detects signed overflow by looking only at the signs of the operands and of the result.

A mode input selects what happens when an arithmetic result overflows. In wrap mode the truncated result passes through and no flag is raised. In saturate mode the result is clamped to the extreme value whose sign matches the true result. In trap mode a redirect request goes out to a fixed handler address, and the program counter of the faulting operation is saved in an exception PC register.

The saved exception PC can be read back through a read-enable port, so that a handler can find out where execution should resume. The result, the overflow flag and the trap request are combinational in the same cycle as the operands. The exception PC register loads on the clock edge that ends the trapping cycle.

Top module: `alu_ovf_unit`

## Requirements
- R1: Operation code 0 gives `a AND b` and code 1 gives `a OR b`. Neither code ever raises the overflow flag or the trap request, in any mode.
- R2: Code 2 gives the sum and code 3 gives the difference `a - b`, each truncated to DATA_W bits, whenever saturation is not applied.
- R3: An addition overflows when both operands are non-negative and the result is negative, or when both operands are negative and the result is non-negative.
- R4: A subtraction overflows when `a` is non-negative, `b` is negative and the result is negative, or when `a` is negative, `b` is non-negative and the result is non-negative.
- R5: Mode codes 0 and 3 are wrap modes. In them the truncated result is output and neither the overflow flag nor the trap request is ever raised.
- R6: In mode code 1 (saturate), an overflowing result is replaced by 0x7FFFFFFF when the true result is positive and by 0x80000000 when it is negative, and the overflow flag is raised.
- R7: In mode code 2 (trap), an overflow raises the overflow flag. An overflow that coincides with a high valid input also raises the trap request. The redirect address output always carries the fixed handler address, which defaults to 0x80000180.
- R8: The exception PC register loads the PC input on the clock edge that ends a cycle in which the trap request is high. It keeps its value on every other edge, and it resets to zero.
- R9: With the read enable high, the read data output shows the exception PC register. With the read enable low, it shows zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | The operation in this cycle is a real issued operation |
| op_i | input | 2 | Operation: 0 AND, 1 OR, 2 add, 3 subtract |
| mode_i | input | 2 | Overflow policy: 0 or 3 wrap, 1 saturate, 2 trap |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand (subtrahend for code 3) |
| pc_i | input | PC_W | PC of the operation in this cycle |
| res_o | output | DATA_W | Result after the overflow policy is applied |
| ovf_o | output | 1 | Overflow flag (saturate and trap modes only) |
| trap_o | output | 1 | Redirect request to the handler |
| redirect_pc_o | output | PC_W | Fixed handler address |
| epc_rd_i | input | 1 | Read enable for the exception PC |
| epc_rd_data_o | output | PC_W | Exception PC when read is enabled, else zero |

## Verification
The result, the overflow flag, the trap request and the read data depend only on current inputs and the current register state. The bench therefore drives each operation on a falling edge and compares these outputs one nanosecond later, inside the same cycle. The exception PC due from a trap becomes visible after the next rising edge. The reference model updates its own copy of the register at that edge, so the read data are compared in the following cycle. Hold behaviour is exercised by issuing overflows with valid low, overflows in non-trap modes, and trap-mode operations that do not overflow, each followed by a read of the register.

// File: rtl/alu_ovf_pkg.sv
package alu_ovf_pkg;

   typedef enum logic [1:0] {
      OP_AND = 2'd0,
      OP_OR  = 2'd1,
      OP_ADD = 2'd2,
      OP_SUB = 2'd3
   } alu_op_e;

   typedef enum logic [1:0] {
      OVM_WRAP     = 2'd0,
      OVM_SAT      = 2'd1,
      OVM_TRAP     = 2'd2,
      OVM_WRAP_ALT = 2'd3
   } ovf_mode_e;

endpackage

// File: rtl/alu_ovf_core.sv
module alu_ovf_core
   import alu_ovf_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  alu_op_e           op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] raw_o,
   output logic              ovf_o
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] arith;
   logic              is_sub;
   logic              is_arith;

   assign is_sub   = (op_i == OP_SUB);
   assign is_arith = (op_i == OP_ADD) || (op_i == OP_SUB);

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [DATA_W-1:0] b_eff;
         assign b_eff = is_sub ? ~b_i : b_i;
         assign arith = a_i + b_eff + {{(DATA_W-1){1'b0}}, is_sub};
      end else begin : g_split
         logic [DATA_W-1:0] sum_r;
         logic [DATA_W-1:0] dif_r;
         assign sum_r = a_i + b_i;
         assign dif_r = a_i - b_i;
         assign arith = is_sub ? dif_r : sum_r;
      end
   endgenerate

   always_comb begin
      unique case (op_i)
         OP_AND:  raw_o = a_i & b_i;
         OP_OR:   raw_o = a_i | b_i;
         default: raw_o = arith;
      endcase
   end

   // Sign rule: operands of effectively equal sign, result of the other sign.
   logic same_sign;
   assign same_sign = is_sub ? (a_i[MSB] != b_i[MSB]) : (a_i[MSB] == b_i[MSB]);
   assign ovf_o     = is_arith && same_sign && (arith[MSB] != a_i[MSB]);

   // R1: logic operations never overflow
   assert_logic_no_ovf_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_AND || op_i == OP_OR) |-> !ovf_o);

   // R3: adding operands of opposite sign can never overflow
   assert_add_mixed_sign_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_ADD && a_i[MSB] != b_i[MSB]) |-> !ovf_o);

   // R4: subtracting operands of equal sign can never overflow
   assert_sub_same_sign_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_SUB && a_i[MSB] == b_i[MSB]) |-> !ovf_o);

endmodule

// File: rtl/alu_ovf_policy.sv
module alu_ovf_policy
   import alu_ovf_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              valid_i,
   input  ovf_mode_e         mode_i,
   input  logic [DATA_W-1:0] raw_i,
   input  logic              ovf_i,
   output logic [DATA_W-1:0] res_o,
   output logic              flag_o,
   output logic              trap_o
);
   localparam int                MSB     = DATA_W - 1;
   localparam logic [DATA_W-1:0] SAT_MAX = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] SAT_MIN = {1'b1, {(DATA_W-1){1'b0}}};

   logic clamp;
   assign clamp = ovf_i && (mode_i == OVM_SAT);

   // A wrapped overflow has the wrong sign: negative raw means a positive true result.
   always_comb begin
      if (clamp) res_o = raw_i[MSB] ? SAT_MAX : SAT_MIN;
      else       res_o = raw_i;
   end

   assign flag_o = ovf_i && (mode_i == OVM_SAT || mode_i == OVM_TRAP);
   assign trap_o = valid_i && ovf_i && (mode_i == OVM_TRAP);

   // R6: a clamped value always differs from the wrapped one
   assert_sat_changes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == OVM_SAT && ovf_i) |-> (res_o != raw_i));

   // R5: wrap modes pass the raw value with no flag
   assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == OVM_WRAP || mode_i == OVM_WRAP_ALT) |-> (!flag_o && !trap_o && res_o == raw_i));

   // R7: a trap request always comes with the flag and a valid operation
   assert_trap_flagged_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap_o |-> (flag_o && valid_i));

endmodule

// File: rtl/alu_ovf_epc.sv
module alu_ovf_epc #(
   parameter int PC_W = 32
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            cap_i,
   input  logic [PC_W-1:0] pc_i,
   input  logic            rd_i,
   output logic [PC_W-1:0] rd_data_o
);
   logic [PC_W-1:0] epc_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    epc_q <= '0;
      else if (cap_i) epc_q <= pc_i;
   end

   assign rd_data_o = rd_i ? epc_q : '0;

   // R8: capture on a trap cycle
   assert_epc_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_i |=> (epc_q == $past(pc_i)));

   // R8: hold on every other cycle
   assert_epc_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cap_i |=> $stable(epc_q));

   // R9: disabled read shows zero
   assert_rd_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_i |-> (rd_data_o == '0));

endmodule

// File: rtl/alu_ovf_unit.sv
module alu_ovf_unit
   import alu_ovf_pkg::*;
#(
   parameter int              DATA_W       = 32,
   parameter int              PC_W         = 32,
   parameter bit              SHARED_ADDER = 1'b1,
   parameter logic [PC_W-1:0] HANDLER_PC   = 32'h8000_0180
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              valid_i,
   input  logic [1:0]        op_i,
   input  logic [1:0]        mode_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [PC_W-1:0]   pc_i,
   output logic [DATA_W-1:0] res_o,
   output logic              ovf_o,
   output logic              trap_o,
   output logic [PC_W-1:0]   redirect_pc_o,
   input  logic              epc_rd_i,
   output logic [PC_W-1:0]   epc_rd_data_o
);
   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("alu_ovf_unit: DATA_W must be at least 2");
      end
      if (PC_W < 2) begin : g_bad_pc_w
         $error("alu_ovf_unit: PC_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] raw;
   logic              ovf_raw;

   alu_ovf_core #(
      .DATA_W       (DATA_W),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_core (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .op_i   (alu_op_e'(op_i)),
      .a_i    (a_i),
      .b_i    (b_i),
      .raw_o  (raw),
      .ovf_o  (ovf_raw)
   );

   alu_ovf_policy #(
      .DATA_W (DATA_W)
   ) u_policy (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_i),
      .mode_i  (ovf_mode_e'(mode_i)),
      .raw_i   (raw),
      .ovf_i   (ovf_raw),
      .res_o   (res_o),
      .flag_o  (ovf_o),
      .trap_o  (trap_o)
   );

   alu_ovf_epc #(
      .PC_W (PC_W)
   ) u_epc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cap_i     (trap_o),
      .pc_i      (pc_i),
      .rd_i      (epc_rd_i),
      .rd_data_o (epc_rd_data_o)
   );

   assign redirect_pc_o = HANDLER_PC;

   // R7: no trap without a valid operation
   assert_trap_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |-> !trap_o);

   // R1: logic codes raise nothing at the ports
   assert_logic_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i[1] == 1'b0) |-> (!ovf_o && !trap_o));

endmodule

// File: tb/alu_ovf_unit_tb.sv
module alu_ovf_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0;
   logic [1:0]  op = 2'd0;
   logic [1:0]  mode = 2'd0;
   logic [31:0] a = '0;
   logic [31:0] b = '0;
   logic [31:0] pc = '0;
   logic        rd = 1'b0;
   logic [31:0] res;
   logic        ovf;
   logic        trap;
   logic [31:0] redir;
   logic [31:0] rd_data;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   logic [31:0] m_epc = '0;

   always #5 clk = ~clk;

   alu_ovf_unit u_dut (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .valid_i       (valid),
      .op_i          (op),
      .mode_i        (mode),
      .a_i           (a),
      .b_i           (b),
      .pc_i          (pc),
      .res_o         (res),
      .ovf_o         (ovf),
      .trap_o        (trap),
      .redirect_pc_o (redir),
      .epc_rd_i      (rd),
      .epc_rd_data_o (rd_data)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic apply(input logic v, input logic [1:0] o, input logic [1:0] m,
                        input logic [31:0] x, input logic [31:0] y,
                        input logic [31:0] p, input logic r);
      longint sx, sy, full;
      logic [31:0] er;
      logic eo, ef, et;
      string tres, tflg;
      @(negedge clk);
      valid = v; op = o; mode = m; a = x; b = y; pc = p; rd = r;
      #1;
      sx = longint'($signed(x));
      sy = longint'($signed(y));
      full = 0;
      eo = 1'b0;
      case (o)
         2'd0: er = x & y;
         2'd1: er = x | y;
         default: begin
            full = (o == 2'd2) ? sx + sy : sx - sy;
            eo = (full > 64'sd2147483647) || (full < -64'sd2147483648);
            er = full[31:0];
         end
      endcase
      tres = (o < 2) ? "R1" : "R2";
      if (m == 2'd1 && eo) begin
         er = (full > 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
         tres = "R6";
      end
      ef = eo && (m == 2'd1 || m == 2'd2);
      et = v && eo && (m == 2'd2);
      if (o < 2)                        tflg = "R1";
      else if (m == 2'd0 || m == 2'd3)  tflg = "R5";
      else if (o == 2'd2)               tflg = "R3";
      else                              tflg = "R4";
      check(tres, "result", res, er);
      check(tflg, "overflow flag", {31'd0, ovf}, {31'd0, ef});
      check("R7", "trap", {31'd0, trap}, {31'd0, et});
      check("R7", "redirect", redir, 32'h8000_0180);
      check(r ? "R8" : "R9", "epc read", rd_data, r ? m_epc : 32'd0);
      @(posedge clk);
      if (et) m_epc = p;
   endtask

   initial begin
      #200000;
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R9 reset value of exception PC is zero
      apply(1'b0, 2'd0, 2'd0, 32'h0, 32'h0, 32'h0, 1'b1);
      // R1 logic ops with sign-extreme operands
      apply(1'b1, 2'd0, 2'd2, 32'hF0F0_7FFF, 32'h8FF0_FFFF, 32'h100, 1'b0);
      apply(1'b1, 2'd1, 2'd1, 32'h7000_0000, 32'h0F00_0001, 32'h104, 1'b1);
      // R3 add overflow both directions, saturate (R6)
      apply(1'b1, 2'd2, 2'd1, 32'h7FFF_FFFF, 32'h0000_0001, 32'h108, 1'b1);
      apply(1'b1, 2'd2, 2'd1, 32'h8000_0000, 32'hFFFF_FFFF, 32'h10C, 1'b1);
      apply(1'b1, 2'd2, 2'd1, 32'h7FFF_FFFE, 32'h0000_0001, 32'h110, 1'b1);
      // R4 subtract overflow both directions, saturate
      apply(1'b1, 2'd3, 2'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h114, 1'b1);
      apply(1'b1, 2'd3, 2'd1, 32'h8000_0000, 32'h0000_0001, 32'h118, 1'b1);
      apply(1'b1, 2'd3, 2'd1, 32'h0000_0000, 32'h8000_0000, 32'h11C, 1'b1);
      apply(1'b1, 2'd3, 2'd1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h120, 1'b1);
      // R5 wrap modes 0 and 3
      apply(1'b1, 2'd2, 2'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h124, 1'b1);
      apply(1'b1, 2'd3, 2'd3, 32'h8000_0000, 32'h0000_0005, 32'h128, 1'b1);
      // R7 overflow in trap mode with valid low: no trap, R8 epc holds
      apply(1'b0, 2'd2, 2'd2, 32'h4000_0000, 32'h4000_0000, 32'h12C, 1'b1);
      apply(1'b1, 2'd0, 2'd0, 32'h0, 32'h0, 32'h130, 1'b1);
      // R7/R8 real trap, then read back
      apply(1'b1, 2'd2, 2'd2, 32'h4000_0000, 32'h4000_0000, 32'h0040_0020, 1'b1);
      apply(1'b1, 2'd2, 2'd2, 32'h0000_0001, 32'h0000_0002, 32'h0040_0024, 1'b1);
      apply(1'b1, 2'd0, 2'd0, 32'h0, 32'h0, 32'h0040_0028, 1'b0);
      apply(1'b1, 2'd0, 2'd0, 32'h0, 32'h0, 32'h0040_002C, 1'b1);
      // R8 second trap overwrites
      apply(1'b1, 2'd3, 2'd2, 32'h8000_0000, 32'h0000_0001, 32'h0040_0100, 1'b1);
      apply(1'b1, 2'd1, 2'd2, 32'h0, 32'h0, 32'h0040_0104, 1'b1);
      // Mixed stimulus with edge-biased operands
      for (int i = 0; i < 400; i++) begin
         logic [31:0] x, y;
         int sel;
         sel = $urandom % 4;
         x = $urandom;
         y = $urandom;
         if (sel == 0) x = {x[31], 31'h7FFF_FFF0 | x[3:0]};
         if (sel == 1) y = {~x[31], y[30:0]};
         apply(($urandom % 4) != 0, 2'($urandom), 2'($urandom), x, y,
               $urandom & 32'hFFFF_FFFC, ($urandom % 3) != 0);
      end
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule